// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Wildcard Fields

This block decides, once per timekeeping update, whether the current time of a real-time clock has reached a programmed alarm time. It compares three time fields (seconds, minutes, hours) against three alarm bytes. When all three fields match, it sets a sticky alarm flag. The interrupt request is that flag gated by an enable bit. The clock counters are outside this block and only present their values on its inputs.

An alarm byte whose two top bits are both 1 (0xC0 to 0xFF) is a wildcard. A wildcard matches every value of its field, so one comparator gives four alarm rates:
- a daily alarm, with no wildcard;
- an hourly alarm, with the hours byte wild;
- a per-minute alarm, with the hours and minutes bytes wild;
- a per-second alarm, with all three bytes wild.

Hours values in 12-hour form carry PM in bit 7, and such values are compared exactly like any other value.

Control is a two-state machine:
- ST_QUIET: the flag is clear.
- ST_RAISED: the flag is set.

Its transitions are:
- RESET: any state to ST_QUIET while `rst_n` is low.
- SET: ST_QUIET to ST_RAISED on a fresh update strobe while all fields match.
- ACK: ST_RAISED to ST_QUIET on a status read, unless a SET happens in the same cycle.
- HOLD: stay in the current state in every other cycle.

An update strobe counts only on its rising edge. A strobe held high for several cycles therefore gives one evaluation.

Top module: `rtc_alarm_match`

## Requirements
- R1: While and right after reset, `alm_flag_o` and `irq_o` are 0.
- R2: When all three time fields equal their alarm bytes (all 8 bits), a rising edge of `upd_done_i` sets `alm_flag_o`. The flag reads 1 from the clock edge that samples the strobe high.
- R3: If any non-wildcard alarm byte differs from its time field in any bit, a strobe leaves the flag at 0.
- R4: An alarm byte with bits 7 and 6 both 1 (0xC0–0xFF) matches every value of its field.
- R5: With the hours byte wild, any hour matches. With the hours and minutes bytes wild, any minute and hour match. With all three bytes wild, every strobe sets the flag.
- R6: A byte with bit 7 set and bit 6 clear (for example PM hours 0x81–0x92, or 0x80/0xBF) is not a wildcard. 0x81 matches only 0x81, never 0x01.
- R7: The flag is set on a match whatever `alm_en_i` is. `irq_o` equals `alm_flag_o` AND `alm_en_i`, with no added register.
- R8: `stat_rd_i` high at a clock edge clears the flag. With no read, the flag holds its value.
- R9: If a read and a matching strobe edge fall on the same clock edge, the flag stays 1.
- R10: A strobe held high for several cycles is evaluated once. A flag cleared while the strobe stays high remains 0.
- R11: Matching time values without a strobe rising edge never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_done_i | input | 1 | Update-complete strobe; its rising edge triggers one evaluation |
| cur_sec_i | input | 8 | Current seconds value |
| cur_min_i | input | 8 | Current minutes value |
| cur_hr_i | input | 8 | Current hours value (bit 7 = PM in 12-hour form) |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| alm_en_i | input | 1 | Alarm interrupt enable |
| stat_rd_i | input | 1 | Status read; clears the flag |
| alm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the time and alarm bytes are stable in any cycle where the strobe is sampled. They also assume that the strobe is low right after reset, so that the first rising edge is a real update. The stimulus changes the data inputs only on falling clock edges, and only while the strobe is low. Every strobe is a single pulse, except in the held-strobe case, where the inputs are frozen for its whole length.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int unsigned N_FIELDS = 3;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } alm_state_e;

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned WILD_BITS = 2
) (
    input  logic [FIELD_W-1:0] cur_i,
    input  logic [FIELD_W-1:0] alm_i,
    output logic               hit_o
);
    localparam int unsigned TOP = FIELD_W - 1;

    logic wild;
    logic equal;

    always_comb begin
        wild  = &alm_i[TOP -: WILD_BITS];
        equal = (cur_i == alm_i);
        hit_o = wild | equal;
    end
endmodule

// File: rtl/alm_flag_fsm.sv
module alm_flag_fsm
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic all_hit_i,
    input  logic rd_clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    alm_state_e state_q, state_d;
    logic       stb_q;
    logic       fresh;
    logic       set_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= upd_i;
    end

    assign fresh   = upd_i & ~stb_q;
    assign set_evt = fresh & all_hit_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (set_evt)               state_d = ST_RAISED;
            ST_RAISED: if (rd_clr_i && !set_evt)  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == ST_RAISED);
        irq_o  = flag_o & en_i;
    end

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_o); // R2
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(upd_i && all_hit_i)); // R11
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !set_evt) |=> !flag_o); // R8
    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !rd_clr_i) |=> flag_o); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && set_evt) |=> flag_o); // R9
    AST_ONE_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && upd_i && stb_q) |=> !flag_o); // R10
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !irq_o); // R7
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned WILD_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_done_i,
    input  logic [FIELD_W-1:0] cur_sec_i,
    input  logic [FIELD_W-1:0] cur_min_i,
    input  logic [FIELD_W-1:0] cur_hr_i,
    input  logic [FIELD_W-1:0] alm_sec_i,
    input  logic [FIELD_W-1:0] alm_min_i,
    input  logic [FIELD_W-1:0] alm_hr_i,
    input  logic               alm_en_i,
    input  logic               stat_rd_i,
    output logic               alm_flag_o,
    output logic               irq_o
);
    localparam int unsigned TOP = FIELD_W - 1;

    logic [FIELD_W-1:0]  cur_arr [N_FIELDS];
    logic [FIELD_W-1:0]  alm_arr [N_FIELDS];
    logic [N_FIELDS-1:0] hit;
    logic                all_hit;

    assign cur_arr[0] = cur_sec_i;
    assign cur_arr[1] = cur_min_i;
    assign cur_arr[2] = cur_hr_i;
    assign alm_arr[0] = alm_sec_i;
    assign alm_arr[1] = alm_min_i;
    assign alm_arr[2] = alm_hr_i;

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        alm_field_cmp #(
            .FIELD_W   (FIELD_W),
            .WILD_BITS (WILD_BITS)
        ) i_cmp (
            .cur_i (cur_arr[f]),
            .alm_i (alm_arr[f]),
            .hit_o (hit[f])
        );
    end

    assign all_hit = &hit;

    alm_flag_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (upd_done_i),
        .all_hit_i (all_hit),
        .rd_clr_i  (stat_rd_i),
        .en_i      (alm_en_i),
        .flag_o    (alm_flag_o),
        .irq_o     (irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!alm_flag_o && !irq_o)); // R1
    AST_WILD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (&alm_hr_i[TOP -: WILD_BITS]) |-> hit[2]); // R4
    AST_ALL_WILD: assert property (@(posedge clk) disable iff (!rst_n)
        ((&alm_sec_i[TOP -: WILD_BITS]) && (&alm_min_i[TOP -: WILD_BITS])
         && (&alm_hr_i[TOP -: WILD_BITS])) |-> all_hit); // R5
    AST_PM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&alm_hr_i[TOP -: WILD_BITS]) && hit[2]) |-> (cur_hr_i == alm_hr_i)); // R6
    AST_MISMATCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&alm_sec_i[TOP -: WILD_BITS]) && (cur_sec_i != alm_sec_i)) |-> !all_hit); // R3
endmodule

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd = 1'b0;
    logic [7:0] cs = '0, cm = '0, ch = '0;
    logic [7:0] as_ = '0, am = '0, ah = '0;
    logic       en = 1'b0;
    logic       rd = 1'b0;
    logic       flag, irq;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    rtc_alarm_match i_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n), .upd_done_i(upd),
        .cur_sec_i(cs), .cur_min_i(cm), .cur_hr_i(ch),
        .alm_sec_i(as_), .alm_min_i(am), .alm_hr_i(ah),
        .alm_en_i(en), .stat_rd_i(rd),
        .alm_flag_o(flag), .irq_o(irq)
    );

    // {expect, cur sec, cur min, cur hr, alarm sec, alarm min, alarm hr}
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 8'h45, 8'h30, 8'h12, 8'h45, 8'h30, 8'h12}, // R2 daily exact
        {1'b0, 8'h45, 8'h30, 8'h12, 8'h45, 8'h30, 8'h13}, // R3 hour differs
        {1'b0, 8'h45, 8'h30, 8'h12, 8'h44, 8'h30, 8'h12}, // R3 second differs
        {1'b1, 8'h45, 8'h30, 8'h07, 8'h45, 8'h30, 8'hC0}, // R5 hourly
        {1'b1, 8'h45, 8'h59, 8'h23, 8'h45, 8'hC5, 8'hFF}, // R5 per minute
        {1'b1, 8'h17, 8'h08, 8'h92, 8'hC0, 8'hE3, 8'hFF}, // R5 per second
        {1'b0, 8'h45, 8'h31, 8'h12, 8'h45, 8'h30, 8'hC0}, // R4 wild hr, min differs
        {1'b1, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h81}, // R6 PM match
        {1'b0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h81}, // R6 PM vs AM
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80}, // R6 0x80 not wild
        {1'b1, 8'h59, 8'h59, 8'h92, 8'h59, 8'h59, 8'h92}, // R6 12 PM
        {1'b0, 8'h00, 8'h00, 8'h00, 8'hBF, 8'h00, 8'h00}  // R6 0xBF not wild
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk) upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    task automatic load(input logic [48:0] v);
        @(negedge clk);
        {cs, cm, ch, as_, am, ah} = v[47:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", {7'd0, flag}, 8'd0);
        chk("R1 irq in reset", {7'd0, irq}, 8'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag after reset", {7'd0, flag}, 8'd0);

        for (int k = 0; k < NV; k++) begin
            clear_flag();
            load(VEC[k]);
            strobe();
            chk($sformatf("R2/R3/R4/R5/R6 vector %0d flag", k), {7'd0, flag}, {7'd0, VEC[k][48]});
            chk($sformatf("R7 vector %0d irq", k), {7'd0, irq}, {7'd0, VEC[k][48]});
        end

        // R11: matching inputs, no strobe
        clear_flag();
        load(VEC[0]);
        repeat (4) @(negedge clk);
        chk("R11 no strobe", {7'd0, flag}, 8'd0);

        // R7: enable off still sets flag, irq masked, then irq follows enable
        @(negedge clk) en = 1'b0;
        strobe();
        chk("R7 flag with enable off", {7'd0, flag}, 8'd1);
        chk("R7 irq masked", {7'd0, irq}, 8'd0);
        en = 1'b1;
        #1 chk("R7 irq follows enable", {7'd0, irq}, 8'd1);

        // R8: hold then clear
        repeat (5) @(negedge clk);
        chk("R8 flag holds", {7'd0, flag}, 8'd1);
        clear_flag();
        chk("R8 read clears", {7'd0, flag}, 8'd0);

        // R9: read and matching strobe together
        strobe();
        @(negedge clk) begin upd = 1'b0; rd = 1'b0; end
        @(negedge clk) begin upd = 1'b1; rd = 1'b1; end
        @(negedge clk) begin upd = 1'b0; rd = 1'b0; end
        chk("R9 set wins over read", {7'd0, flag}, 8'd1);

        // R10: strobe held high is one evaluation
        clear_flag();
        @(negedge clk) upd = 1'b1;
        @(negedge clk);
        chk("R10 held strobe sets", {7'd0, flag}, 8'd1);
        rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 no re-set while held", {7'd0, flag}, 8'd0);
        upd = 1'b0;

        // R1: reset mid-run clears a set flag
        strobe();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears flag", {7'd0, flag}, 8'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule